// File: doc/BRIEF.md
# Inter-frequency Doppler aid generator

This block runs next to a carrier tracking loop that already follows a satellite on the primary band. On every 1 ms tracking update it converts the primary loop's Doppler, Doppler rate and code-rate measurements into starting values for the tracking loop of the same satellite on a second carrier. The Doppler first has a calibrated inter-band frequency offset removed. It is then scaled by the ratio of the second carrier frequency to the first. Doppler rate is scaled by the same ratio, and code rate passes through unchanged. The offset register is written once after a single calibration and then reused for every channel.

A small sequencer decides when the aid may be used. It has three states. In `ST_UNLOCKED` it waits for the primary lock flag; the transition *lock-seen* moves it to `ST_SETTLE`. There it counts update strobes until a programmable settling count is reached, and the transition *settled* moves it to `ST_TRACK`. Only in `ST_TRACK` are aid sets emitted. The transition *lock-lost* returns from either locked state to `ST_UNLOCKED` as soon as the lock flag falls. With each emitted set the block also evaluates a handover permit. The primary 3-sigma frequency error is scaled by the carrier ratio and by a margin factor, then compared with the secondary loop's initial tolerance. The permit says whether the secondary loop may start directly, with no acquisition of its own.

All frequency quantities are signed 32-bit values in millihertz. The carrier ratio and the margin factor are unsigned Q2.22 parameters.

Top module: `ifaid_gen`

## Requirements
- R1: While reset is active and after it is released, all aid outputs are zero and `aid_valid_o` and `handover_ok_o` are low.
- R2: An emitted Doppler aid equals (dop_i − bias) × RATIO_Q / 2^22. It is rounded half up, by adding 2^21 before an arithmetic shift right by 22. The bias is the value held in the offset register.
- R3: An emitted Doppler-rate aid equals drift_i × RATIO_Q / 2^22, with the same rounding as R2 and no bias applied.
- R4: An emitted code-rate aid equals cdrift_i unchanged.
- R5: Scaled results beyond the signed 32-bit range saturate to 2^31−1 or −2^31. The sign of a result never differs from the sign of its input.
- R6: An update strobe sampled at a rising edge produces its aid on the second rising edge after it. `aid_valid_o` is high for exactly that one cycle and is low one cycle after the strobe.
- R7: No aid is emitted until the lock flag has been seen. After that, `settle_i` update strobes must have been counted in `ST_SETTLE`; only strobes that arrive in `ST_TRACK` emit.
- R8: When `lock_i` is low at a rising edge, the sequencer is in `ST_UNLOCKED` after that edge and the settle count restarts. `handover_ok_o` is low after that edge, and a strobe in flight produces no valid pulse.
- R9: At each emission `handover_ok_o` takes the value (round(round(err3s_i × RATIO_Q) × SCALE_Q) ≤ TOL_MHZ), each rounding as in R2. It holds that value until the next emission or until lock is lost.
- R10: A cycle with `bias_load_i` high stores `bias_val_i` into the offset register. The register keeps its value for all later updates until the next load, and it resets to zero.
- R11: Between emissions all aid outputs keep their last emitted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | One-cycle strobe marking a new 1 ms primary tracking update |
| lock_i | input | 1 | Primary carrier loop lock flag |
| settle_i | input | SW | Settling time, counted in update strobes after lock |
| dop_i | input | DW | Primary Doppler, signed, mHz |
| drift_i | input | DW | Primary Doppler rate, signed |
| cdrift_i | input | DW | Primary code rate, signed |
| err3s_i | input | DW | Primary 3-sigma frequency error, unsigned, mHz |
| bias_load_i | input | 1 | Write strobe for the inter-band offset |
| bias_val_i | input | DW | Inter-band offset value, signed, mHz |
| aid_dop_o | output | DW | Secondary Doppler aid |
| aid_drift_o | output | DW | Secondary Doppler-rate aid |
| aid_cdrift_o | output | DW | Secondary code-rate aid |
| aid_valid_o | output | 1 | One-cycle pulse marking a new aid set |
| handover_ok_o | output | 1 | Direct handover permitted |

## Verification
The bench uses the default parameters. RATIO_Q is 3268361, which approximates the L2/L1 carrier ratio of about 0.779. SCALE_Q is 4613734, a margin factor of about 1.1, and TOL_MHZ is 35000. With these values the handover threshold falls near a 40.8 Hz primary error, so random errors from 20 to 60 Hz land on both sides of it. Directed errors of 30, 40.8 and 50 Hz bracket the threshold. Although the ratio is below one, the offset subtraction widens the Doppler by one bit, so a positive full-scale Doppler with a negative full-scale offset reaches both saturation limits. Settling counts of 0, 2 and 3 strobes, together with a lock drop while a strobe is in flight, exercise every sequencer transition.

// File: rtl/ifaid_pkg.sv
package ifaid_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_SETTLE   = 2'd1,
        ST_TRACK    = 2'd2
    } aid_state_t;

endpackage

// File: rtl/ifaid_scale.sv
// Signed value times unsigned fixed-point coefficient, round half up, saturate.
module ifaid_scale #(
    parameter int IW = 33,
    parameter int CW = 24,
    parameter int F  = 22,
    parameter int OW = 32
) (
    input  logic signed [IW-1:0] a_i,
    input  logic        [CW-1:0] k_i,
    output logic signed [OW-1:0] y_o
);
    localparam int PW = IW + CW + 1;
    localparam logic signed [PW-1:0] HALF = {{(PW-F){1'b0}}, 1'b1, {(F-1){1'b0}}};
    localparam logic signed [PW-1:0] MAXV = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] k_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd_v;

    always_comb begin
        a_ext = {{(PW-IW){a_i[IW-1]}}, a_i};
        k_ext = {{(PW-CW){1'b0}}, k_i};
        prod  = a_ext * k_ext;
        rnd_v = (prod + HALF) >>> F;
        if (rnd_v > MAXV) begin
            y_o = MAXV[OW-1:0];
        end else if (rnd_v < MINV) begin
            y_o = MINV[OW-1:0];
        end else begin
            y_o = rnd_v[OW-1:0];
        end
    end

    always_comb begin
        if (!a_i[IW-1]) begin
            AST_SIGN_KEEP: assert (!y_o[OW-1]); // R5
        end
    end

endmodule

// File: rtl/ifaid_lockseq.sv
// Lock / settle / track sequencer.
module ifaid_lockseq
    import ifaid_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_i,
    input  logic          upd_i,
    input  logic [SW-1:0] settle_i,
    output logic          track_o
);
    aid_state_t    state_q;
    aid_state_t    state_d;
    logic [SW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: if (lock_i) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!lock_i)                state_d = ST_UNLOCKED;
                else if (cnt_q >= settle_i) state_d = ST_TRACK;
            end
            ST_TRACK: if (!lock_i) state_d = ST_UNLOCKED;
            default:  state_d = ST_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_SETTLE) begin
            cnt_q <= '0;
        end else if (upd_i && cnt_q < settle_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        track_o = (state_q == ST_TRACK);
    end

    AST_UNLOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> (state_q == ST_UNLOCKED)); // R8

    AST_TRACK_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && $past(state_q) != ST_TRACK) |-> ($past(state_q) == ST_SETTLE)); // R7

endmodule

// File: rtl/ifaid_gen.sv
// Inter-frequency Doppler aid generator, top level.
module ifaid_gen #(
    parameter int            DW      = 32,
    parameter int            CW      = 24,
    parameter int            FRAC    = 22,
    parameter int            SW      = 16,
    parameter logic [CW-1:0] RATIO_Q = 24'd3268361,
    parameter logic [CW-1:0] SCALE_Q = 24'd4613734,
    parameter logic [DW-1:0] TOL_MHZ = 32'd35000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  logic                 lock_i,
    input  logic [SW-1:0]        settle_i,
    input  logic signed [DW-1:0] dop_i,
    input  logic signed [DW-1:0] drift_i,
    input  logic signed [DW-1:0] cdrift_i,
    input  logic [DW-1:0]        err3s_i,
    input  logic                 bias_load_i,
    input  logic signed [DW-1:0] bias_val_i,
    output logic signed [DW-1:0] aid_dop_o,
    output logic signed [DW-1:0] aid_drift_o,
    output logic signed [DW-1:0] aid_cdrift_o,
    output logic                 aid_valid_o,
    output logic                 handover_ok_o
);
    localparam int DFW = DW + 1;
    localparam int BW1 = DW + 3;
    localparam int BW2 = DW + 4;
    localparam logic signed [BW2-1:0] TOL_EXT = {{(BW2-DW){1'b0}}, TOL_MHZ};

    logic                  track;
    logic                  emit;
    logic signed [DW-1:0]  bias_q;

    logic                  s1_v;
    logic signed [DFW-1:0] s1_diff;
    logic signed [DW-1:0]  s1_drift;
    logic signed [DW-1:0]  s1_cd;
    logic signed [BW1-1:0] s1_b1;

    logic signed [DFW-1:0] err_ext;
    logic signed [BW1-1:0] b1_y;
    logic signed [BW2-1:0] b2_y;
    logic signed [DW-1:0]  dop_y;
    logic signed [DW-1:0]  drift_y;
    logic                  permit_ok;

    ifaid_lockseq #(.SW(SW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (lock_i),
        .upd_i    (upd_i),
        .settle_i (settle_i),
        .track_o  (track)
    );

    always_comb begin
        emit    = upd_i && track && lock_i;
        err_ext = {1'b0, err3s_i};
    end

    // offset register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bias_q <= '0;
        end else if (bias_load_i) begin
            bias_q <= bias_val_i;
        end
    end

    // stage 1: bias removal and first bound product
    ifaid_scale #(.IW(DFW), .CW(CW), .F(FRAC), .OW(BW1)) u_bnd1 (
        .a_i (err_ext), .k_i (RATIO_Q), .y_o (b1_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_diff  <= '0;
            s1_drift <= '0;
            s1_cd    <= '0;
            s1_b1    <= '0;
        end else begin
            s1_v <= emit;
            if (emit) begin
                s1_diff  <= {dop_i[DW-1], dop_i} - {bias_q[DW-1], bias_q};
                s1_drift <= drift_i;
                s1_cd    <= cdrift_i;
                s1_b1    <= b1_y;
            end
        end
    end

    // stage 2: carrier-ratio scaling and bound test
    ifaid_scale #(.IW(DFW), .CW(CW), .F(FRAC), .OW(DW)) u_dop (
        .a_i (s1_diff), .k_i (RATIO_Q), .y_o (dop_y)
    );

    ifaid_scale #(.IW(DW), .CW(CW), .F(FRAC), .OW(DW)) u_drift (
        .a_i (s1_drift), .k_i (RATIO_Q), .y_o (drift_y)
    );

    ifaid_scale #(.IW(BW1), .CW(CW), .F(FRAC), .OW(BW2)) u_bnd2 (
        .a_i (s1_b1), .k_i (SCALE_Q), .y_o (b2_y)
    );

    always_comb begin
        permit_ok = (b2_y <= TOL_EXT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aid_dop_o     <= '0;
            aid_drift_o   <= '0;
            aid_cdrift_o  <= '0;
            aid_valid_o   <= 1'b0;
            handover_ok_o <= 1'b0;
        end else begin
            aid_valid_o <= s1_v && lock_i;
            if (s1_v && lock_i) begin
                aid_dop_o     <= dop_y;
                aid_drift_o   <= drift_y;
                aid_cdrift_o  <= s1_cd;
                handover_ok_o <= permit_ok;
            end else if (!lock_i) begin
                handover_ok_o <= 1'b0;
            end
        end
    end

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        aid_valid_o |-> $past(lock_i)); // R8

    AST_PERMIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> !handover_ok_o); // R8

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        aid_valid_o |-> $past(upd_i, 2)); // R6

    AST_HOLD_AIDS: assert property (@(posedge clk) disable iff (!rst_n)
        !aid_valid_o |-> ($stable(aid_dop_o) && $stable(aid_drift_o) && $stable(aid_cdrift_o))); // R11

endmodule

// File: tb/ifaid_gen_test.sv
`timescale 1ns/1ps
module ifaid_gen_test;

    localparam longint RATIO = 64'sd3268361;
    localparam longint SCALE = 64'sd4613734;
    localparam longint TOL   = 64'sd35000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               upd = 1'b0;
    logic               lock = 1'b0;
    logic [15:0]        settle = 16'd0;
    logic signed [31:0] dop = '0;
    logic signed [31:0] drift = '0;
    logic signed [31:0] cdrift = '0;
    logic [31:0]        err = '0;
    logic               bload = 1'b0;
    logic signed [31:0] bval = '0;
    logic signed [31:0] aid_dop;
    logic signed [31:0] aid_drift;
    logic signed [31:0] aid_cdrift;
    logic               aid_valid;
    logic               hov_ok;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done = 1'b0;
    longint bias_m = 0;
    longint e_dop = 0, e_drift = 0, e_cd = 0, e_hov = 0;
    bit     lk = 1'b0;
    int     since = 0;
    int     settle_m = 0;

    always #2.5 clk = ~clk;

    ifaid_gen uut (
        .clk (clk), .rst_n (rst_n), .upd_i (upd), .lock_i (lock),
        .settle_i (settle), .dop_i (dop), .drift_i (drift), .cdrift_i (cdrift),
        .err3s_i (err), .bias_load_i (bload), .bias_val_i (bval),
        .aid_dop_o (aid_dop), .aid_drift_o (aid_drift), .aid_cdrift_o (aid_cdrift),
        .aid_valid_o (aid_valid), .handover_ok_o (hov_ok)
    );

    function automatic longint rnd_q(input longint a, input longint k);
        return (a * k + 64'sd2097152) >>> 22;
    endfunction

    function automatic longint sat32(input longint x);
        if (x > 64'sd2147483647) return 64'sd2147483647;
        if (x < -64'sd2147483648) return -64'sd2147483648;
        return x;
    endfunction

    function automatic longint permit(input longint e);
        return (rnd_q(rnd_q(e, RATIO), SCALE) <= TOL) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_bias(input longint b);
        @(negedge clk);
        bval = b[31:0]; bload = 1'b1;
        @(negedge clk);
        bload = 1'b0;
        bias_m = b;
    endtask

    task automatic set_lock(input bit v, input int s);
        @(negedge clk);
        lock = v; settle = 16'(s); settle_m = s;
        lk = v; since = 0;
        if (!v) e_hov = 0;
        repeat (3) @(negedge clk);
    endtask

    // one update; drop=1 lowers lock while the strobe is in flight
    task automatic do_upd(input longint d, input longint dr, input longint cd,
                          input longint e, input string dtag, input bit drop);
        bit emit;
        @(negedge clk);
        dop = d[31:0]; drift = dr[31:0]; cdrift = cd[31:0]; err = e[31:0];
        upd = 1'b1;
        emit = lk && (since >= settle_m);
        if (lk) since++;
        @(negedge clk);
        upd = 1'b0;
        chk("R6 no valid one cycle after strobe", aid_valid, 0);
        if (drop) begin
            lock = 1'b0; lk = 1'b0; since = 0; emit = 1'b0; e_hov = 0;
        end
        @(negedge clk);
        if (emit) begin
            e_dop   = sat32(rnd_q(d - bias_m, RATIO));
            e_drift = sat32(rnd_q(dr, RATIO));
            e_cd    = cd;
            e_hov   = permit(e);
        end
        chk(drop ? "R8 valid suppressed on lock drop" : "R7 R6 valid pulse", aid_valid, emit);
        chk(dtag, aid_dop, e_dop);
        chk("R3 drift aid", aid_drift, e_drift);
        chk("R4 code drift aid", aid_cdrift, e_cd);
        chk(drop ? "R8 permit cleared" : "R9 handover permit", hov_ok, e_hov);
        @(negedge clk);
        chk("R6 valid single cycle", aid_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211));
        repeat (4) @(negedge clk);
        chk("R1 reset dop", aid_dop, 0);
        chk("R1 reset valid", aid_valid, 0);
        chk("R1 reset permit", hov_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset drift", aid_drift, 0);
        chk("R1 after reset cdrift", aid_cdrift, 0);

        // unlocked: strobes ignored
        do_upd(1000000, 50, 7, 30000, "R7 dop unchanged while unlocked", 1'b0);

        load_bias(1234567);
        set_lock(1'b1, 3);
        for (int i = 0; i < 3; i++) do_upd(2000000 + i, 10, 3, 30000, "R7 dop held while settling", 1'b0);
        do_upd(2500000, -400, 12, 30000, "R2 first aid after settle", 1'b0);

        // random updates, same bias throughout
        for (int i = 0; i < 40; i++) begin
            longint d, dr, cd, e;
            d  = longint'($urandom_range(0, 10000000)) - 5000000;
            dr = longint'($urandom_range(0, 200000)) - 100000;
            cd = longint'($urandom_range(0, 20000)) - 10000;
            e  = 20000 + longint'($urandom_range(0, 40000));
            do_upd(d, dr, cd, e, "R2 R10 dop aid with stored bias", 1'b0);
        end

        // hold between emissions
        repeat (6) @(negedge clk);
        chk("R11 dop held", aid_dop, e_dop);
        chk("R11 drift held", aid_drift, e_drift);

        // permit boundary
        do_upd(100000, 0, 0, 30000, "R2 dop", 1'b0);
        do_upd(100000, 0, 0, 40800, "R2 dop", 1'b0);
        do_upd(100000, 0, 0, 40900, "R2 dop", 1'b0);
        do_upd(100000, 0, 0, 50000, "R2 dop", 1'b0);

        // saturation
        load_bias(-64'sd2147483648);
        do_upd(64'sd2147483647, 64'sd2147483647, -64'sd2147483648, 30000, "R5 positive saturation", 1'b0);
        load_bias(64'sd2147483647);
        do_upd(-64'sd2147483648, -64'sd2147483648, 64'sd2147483647, 30000, "R5 negative saturation", 1'b0);
        load_bias(-5000);

        // lock drop with a strobe in flight
        do_upd(300000, 20, 1, 30000, "R2 dop before drop", 1'b0);
        chk("R9 permit set before drop", hov_ok, 1);
        do_upd(400000, 20, 1, 30000, "R8 dop unchanged on drop", 1'b1);
        set_lock(1'b0, 2);
        do_upd(500000, 20, 1, 30000, "R8 dop unchanged while unlocked", 1'b0);

        // relock: settle count restarts
        set_lock(1'b1, 2);
        do_upd(600000, 20, 1, 30000, "R7 no aid settle 1", 1'b0);
        do_upd(700000, 20, 1, 30000, "R7 no aid settle 2", 1'b0);
        do_upd(800000, 20, 1, 30000, "R10 dop with reloaded bias", 1'b0);

        // zero settling
        set_lock(1'b0, 0);
        set_lock(1'b1, 0);
        do_upd(-900000, -33, -4, 60000, "R7 aid with zero settle", 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule